// File: doc/BRIEF.md
# SPI Control Register with Interrupt Merge and Baud Timer

This block holds the 8-bit configuration register of a serial peripheral interface unit. It also holds the interrupt request logic around that register. A register bus writes and reads a small four-byte window at a base address. The configuration bits drive straight to the serial shifter: enable, master/slave role, clock polarity, clock phase and open-drain pad mode. The block also shapes the four pad drivers (SCK, SS, MISO, MOSI). It holds SCK at its idle level while no clock runs, and it turns every pad into a low-only driver when open-drain mode is set.

Three sources share a single sticky status flag. The first is a software-forced request bit in the control register. The second is a transfer-complete pulse from the shifter. The third is a timeout of a reload down-counter baud timer. An interrupt-enable bit gates the flag onto the request line. The baud timer runs whenever the peripheral is enabled. While the peripheral is disabled it can run on its own as a general timer with its own timeout interrupt.

Register window (offset from the base): 0 control, 1 status, 2 reload low byte, 3 reload high byte. Control bits: 7 interrupt enable, 6 force request, 5 timer enable, 4 clock phase, 3 clock polarity, 2 open-drain, 1 master, 0 peripheral enable. In the status byte, bit 7 is the flag and the other bits read 0.

Top module: `spi_ctl_irq`

## Requirements
- R1: After reset, every register byte reads 0x00, irq_req is 0 and the timer does not tick. The reset is asserted asynchronously and released two clock edges after rst_n rises.
- R2: A bus write to offset 0 loads all control bits and reads back from offset 0 in the next cycle. A write to an address outside the window changes nothing.
- R3: irq_req is 1 exactly when control bit 7 and the status flag (status bit 7) are both 1.
- R4: Writing control bit 6 as 1 sets the status flag and keeps bit 6 at 1. Writing it as 0 leaves bit 6 unchanged.
- R5: Writing status with bit 7 = 1 clears the flag and control bit 6. A status write with bit 7 = 0 has no effect. Otherwise the flag stays set until it is cleared.
- R6: A cycle of xfer_done sets the flag only while control bit 0 is 1.
- R7: If a set source and a status clear fall in the same cycle, the flag ends up set.
- R8: The 16-bit timer runs while control bit 0 or bit 5 is 1, and brg_tick then pulses once every max(reload,1) cycles. While neither bit is set it is held at the reload value and does not tick. The reload bytes read back at offsets 2 and 3.
- R9: A timer tick sets the flag only when control bit 0 is 0 and bit 5 is 1.
- R10: Pad 0 (SCK) outputs the polarity bit (control bit 3) while sh_sck_run is 0. While sh_sck_run is 1 it outputs sh_out[0] XOR polarity.
- R11: With control bit 2 = 1, every pad_out is 0 and pad_oe[i] = sh_oe[i] AND NOT value[i]. With bit 2 = 0, pad_out carries the value and pad_oe carries sh_oe.
- R12: cfg_en, cfg_master, cfg_od, cfg_cpol and cfg_cpha follow control bits 0, 1, 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| xfer_done | input | 1 | Transfer-complete pulse from the shifter |
| sh_sck_run | input | 1 | Shifter is generating clock edges |
| sh_out | input | 4 | Shifter pad values: 0 SCK, 1 SS, 2 MISO, 3 MOSI |
| sh_oe | input | 4 | Shifter pad output enables, same order |
| cfg_en | output | 1 | Peripheral enable |
| cfg_master | output | 1 | 1 master, 0 slave |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_od | output | 1 | Open-drain pad mode |
| brg_tick | output | 1 | Baud timer reload pulse |
| irq_req | output | 1 | Request to the interrupt controller |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |

## Verification
Any wrong flag or force bit shows on the status read and on irq_req in the cycle after the edge that corrupted it. A stuck flag also shows as a request that no clear can remove. A wrong timer count shows in brg_tick at the next expected reload point, within one reload period, and one cycle later as a flag set or missed while the timer owns the interrupt. A behavioural model is compared every cycle against reads, configuration outputs, tick and pads, in directed phases and in a random phase.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int DW = 8;

  localparam int B_EN     = 0;
  localparam int B_MST    = 1;
  localparam int B_OD     = 2;
  localparam int B_CPOL   = 3;
  localparam int B_CPHA   = 4;
  localparam int B_TMR    = 5;
  localparam int B_FORCE  = 6;
  localparam int B_IE     = 7;
  localparam int ST_FLAG  = 7;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          xfer_done,
  input  logic          tmr_evt,
  output logic [DW-1:0] ctl_q,
  output logic          irq_q
);
  logic          set_any;
  logic          clr_req;
  logic [DW-1:0] ctl_d;
  logic          ctl_ce;
  logic          irq_d;
  logic          irq_ce;

  always_comb begin
    set_any = (wr_ctl & wdata[B_FORCE])
            | (xfer_done & ctl_q[B_EN])
            | (tmr_evt & ~ctl_q[B_EN] & ctl_q[B_TMR]);
    clr_req = wr_stat & wdata[ST_FLAG];
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d          = wdata;
      ctl_d[B_FORCE] = ctl_q[B_FORCE] | wdata[B_FORCE];
    end else if (clr_req) begin
      ctl_d[B_FORCE] = 1'b0;
    end
    ctl_ce = wr_ctl | clr_req;
  end

  always_comb begin
    irq_ce = set_any | clr_req;
    irq_d  = set_any ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_ce) begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/spi_ctl_brg.sv
module spi_ctl_brg #(
  parameter int CNT_W = 16,
  parameter int NB    = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NB-1:0]    wr_byte,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] reload_q,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  for (genvar b = 0; b < NB; b++) begin : g_rld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reload_q[b*8 +: 8] <= 8'h00;
      end else if (wr_byte[b]) begin
        reload_q[b*8 +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    tick  = run && (cnt_q <= CNT_W'(1));
    cnt_d = (!run || tick) ? reload_q : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_ctl_pads.sv
module spi_ctl_pads #(
  parameter int NPIN = 4
) (
  input  logic            cpol,
  input  logic            od,
  input  logic            sck_run,
  input  logic [NPIN-1:0] sh_out,
  input  logic [NPIN-1:0] sh_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  logic [NPIN-1:0] val;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == 0) begin : g_clk
      assign val[i] = sck_run ? (sh_out[i] ^ cpol) : cpol;
    end else begin : g_dat
      assign val[i] = sh_out[i];
    end
    assign pad_out[i] = od ? 1'b0 : val[i];
    assign pad_oe[i]  = od ? (sh_oe[i] & ~val[i]) : sh_oe[i];
  end
endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq
  import spi_ctl_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] BASE   = 8'h60,
  parameter int         CNT_W  = 16,
  parameter int         NPIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              xfer_done,
  input  logic              sh_sck_run,
  input  logic [NPIN-1:0]   sh_out,
  input  logic [NPIN-1:0]   sh_oe,
  output logic              cfg_en,
  output logic              cfg_master,
  output logic              cfg_cpol,
  output logic              cfg_cpha,
  output logic              cfg_od,
  output logic              brg_tick,
  output logic              irq_req,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  localparam int NB = CNT_W / 8;

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             hit;
  reg_sel_e         sel;
  logic             wr_ctl;
  logic             wr_stat;
  logic [NB-1:0]    wr_rld;
  logic [DW-1:0]    ctl_q;
  logic             irq_q;
  logic             tmr_run;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync[1];

  always_comb begin
    hit     = (bus_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    sel     = reg_sel_e'(bus_addr[1:0]);
    wr_ctl  = bus_we && hit && (sel == SEL_CTL);
    wr_stat = bus_we && hit && (sel == SEL_STAT);
  end

  for (genvar b = 0; b < NB; b++) begin : g_rld_dec
    assign wr_rld[b] = bus_we && hit && (int'(sel) == 2 + b);
  end

  assign tmr_run = ctl_q[B_EN] | ctl_q[B_TMR];

  spi_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_ctl    (wr_ctl),
    .wr_stat   (wr_stat),
    .wdata     (bus_wdata),
    .xfer_done (xfer_done),
    .tmr_evt   (brg_tick),
    .ctl_q     (ctl_q),
    .irq_q     (irq_q)
  );

  spi_ctl_brg #(.CNT_W(CNT_W), .NB(NB)) u_brg (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .run      (tmr_run),
    .wr_byte  (wr_rld),
    .wdata    (bus_wdata),
    .reload_q (reload_q),
    .tick     (brg_tick)
  );

  spi_ctl_pads #(.NPIN(NPIN)) u_pads (
    .cpol    (ctl_q[B_CPOL]),
    .od      (ctl_q[B_OD]),
    .sck_run (sh_sck_run),
    .sh_out  (sh_out),
    .sh_oe   (sh_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (sel)
        SEL_CTL:  bus_rdata = ctl_q;
        SEL_STAT: bus_rdata = {irq_q, 7'b0};
        SEL_RLO:  bus_rdata = reload_q[7:0];
        SEL_RHI:  bus_rdata = reload_q[CNT_W-1 -: 8];
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign cfg_en     = ctl_q[B_EN];
  assign cfg_master = ctl_q[B_MST];
  assign cfg_cpol   = ctl_q[B_CPOL];
  assign cfg_cpha   = ctl_q[B_CPHA];
  assign cfg_od     = ctl_q[B_OD];
  assign irq_req    = ctl_q[B_IE] & irq_q;
endmodule

// File: rtl/spi_ctl_irq_chk.sv
module spi_ctl_irq_chk
  import spi_ctl_pkg::*;
#(
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            wr_ctl,
  input logic            wr_stat,
  input logic [DW-1:0]   wdata,
  input logic            xfer_done,
  input logic [DW-1:0]   ctl_q,
  input logic            irq_q,
  input logic            brg_tick,
  input logic            sh_sck_run,
  input logic [NPIN-1:0] pad_out
);
  p_force_sets_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_ctl && wdata[B_FORCE]) |=> (irq_q && ctl_q[B_FORCE]));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_stat && wdata[ST_FLAG] && !xfer_done && !brg_tick) |=> (!irq_q && !ctl_q[B_FORCE]));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_q && !(wr_stat && wdata[ST_FLAG])) |=> irq_q);

  p_xfer_sets_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (xfer_done && ctl_q[B_EN]) |=> irq_q);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_stat && wdata[ST_FLAG] && xfer_done && ctl_q[B_EN]) |=> irq_q);

  p_halted_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_q[B_EN] && !ctl_q[B_TMR]) |-> !brg_tick);

  p_tmr_irq_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (brg_tick && !ctl_q[B_EN] && ctl_q[B_TMR]) |=> irq_q);

  p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_q[B_OD] && !sh_sck_run) |-> (pad_out[0] == ctl_q[B_CPOL]));

  p_od_low_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl_q[B_OD] |-> (pad_out == '0));
endmodule

bind spi_ctl_irq spi_ctl_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .wr_ctl     (wr_ctl),
  .wr_stat    (wr_stat),
  .wdata      (bus_wdata),
  .xfer_done  (xfer_done),
  .ctl_q      (ctl_q),
  .irq_q      (irq_q),
  .brg_tick   (brg_tick),
  .sh_sck_run (sh_sck_run),
  .pad_out    (pad_out)
);

// File: tb/spi_ctl_irq_test.sv
module spi_ctl_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h61;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       xfer_done = 1'b0;
  logic       sh_sck_run = 1'b0;
  logic [3:0] sh_out = 4'h0;
  logic [3:0] sh_oe = 4'h0;
  logic       cfg_en, cfg_master, cfg_cpol, cfg_cpha, cfg_od, brg_tick, irq_req;
  logic [3:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] m_ctl = 8'h00;
  bit         m_irq = 0;
  int         m_rld = 0;
  int         m_cnt = 0;
  int         m_rel = 0;

  always #10 clk = ~clk;

  spi_ctl_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
    .sh_sck_run(sh_sck_run), .sh_out(sh_out), .sh_oe(sh_oe),
    .cfg_en(cfg_en), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_od(cfg_od), .brg_tick(brg_tick),
    .irq_req(irq_req), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit m_run();
    return m_ctl[0] | m_ctl[5];
  endfunction

  function automatic bit m_tick();
    return m_run() && (m_cnt <= 1);
  endfunction

  function automatic logic [7:0] m_read(logic [7:0] a);
    if (a[7:2] != 6'h18) return 8'h00;
    case (a[1:0])
      2'd0: return m_ctl;
      2'd1: return {m_irq, 7'b0};
      2'd2: return m_rld[7:0];
      default: return m_rld[15:8];
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ctl = 8'h00; m_irq = 0; m_rld = 0; m_cnt = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit hit, tk, setf, clrf;
      int nxt;
      hit  = (bus_addr[7:2] == 6'h18);
      tk   = m_tick();
      setf = (bus_we && hit && bus_addr[1:0] == 2'd0 && bus_wdata[6])
          || (xfer_done && m_ctl[0])
          || (tk && !m_ctl[0] && m_ctl[5]);
      clrf = bus_we && hit && bus_addr[1:0] == 2'd1 && bus_wdata[7];
      nxt  = (!m_run() || tk) ? m_rld : m_cnt - 1;
      if (bus_we && hit) begin
        case (bus_addr[1:0])
          2'd0: m_ctl = {bus_wdata[7], m_ctl[6] | bus_wdata[6], bus_wdata[5:0]};
          2'd1: if (clrf) m_ctl[6] = 1'b0;
          2'd2: m_rld = (m_rld & 32'hFF00) | int'(bus_wdata);
          default: m_rld = (m_rld & 32'h00FF) | (int'(bus_wdata) << 8);
        endcase
      end
      if (setf) m_irq = 1;
      else if (clrf) m_irq = 0;
      m_cnt = nxt;
    end
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    logic [3:0] v, eo, eoe;
    chk("R2 read data", bus_rdata, m_read(bus_addr));
    chk("R3 irq_req", irq_req, m_ctl[7] & m_irq);
    chk("R12 config", {cfg_en, cfg_master, cfg_od, cfg_cpol, cfg_cpha},
        {m_ctl[0], m_ctl[1], m_ctl[2], m_ctl[3], m_ctl[4]});
    chk("R8 tick", brg_tick, m_tick());
    v    = sh_out;
    v[0] = sh_sck_run ? (sh_out[0] ^ m_ctl[3]) : m_ctl[3];
    eo   = m_ctl[2] ? 4'h0 : v;
    eoe  = m_ctl[2] ? (sh_oe & ~v) : sh_oe;
    chk("R10/R11 pads", {pad_out, pad_oe}, {eo, eoe});
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 8'h61;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] e, string tag);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, e);
  endtask

  task automatic pulse_xfer();
    @(posedge clk); #1; xfer_done = 1'b1;
    @(posedge clk); #1; xfer_done = 1'b0;
  endtask

  task automatic count_ticks(int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (brg_tick) k++;
    end
  endtask

  initial begin
    int k;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    rd_chk(8'h60, 8'h00, "R1 control after reset");
    rd_chk(8'h61, 8'h00, "R1 status after reset");
    rd_chk(8'h63, 8'h00, "R1 reload after reset");
    chk("R1 irq_req after reset", irq_req, 1'b0);
    chk("R1 no tick after reset", brg_tick, 1'b0);

    // R2 / R12: write and read back
    wr(8'h60, 8'h81);
    rd_chk(8'h60, 8'h81, "R2 control readback");
    wr(8'h64, 8'hFF);
    rd_chk(8'h60, 8'h81, "R2 miss write ignored");
    chk("R12 cfg_en", cfg_en, 1'b1);
    chk("R12 cfg_master slave", cfg_master, 1'b0);

    // R6 / R3: transfer complete with enable and interrupt enable
    pulse_xfer();
    rd_chk(8'h61, 8'h80, "R6 xfer sets flag");
    chk("R3 request forwarded", irq_req, 1'b1);
    wr(8'h61, 8'h80);
    rd_chk(8'h61, 8'h00, "R5 clear flag");

    // R3: gated request
    wr(8'h60, 8'h01);
    pulse_xfer();
    rd_chk(8'h61, 8'h80, "R6 flag with gate off");
    chk("R3 request gated", irq_req, 1'b0);
    wr(8'h61, 8'h80);

    // R6: disabled peripheral ignores xfer_done
    wr(8'h60, 8'h00);
    pulse_xfer();
    rd_chk(8'h61, 8'h00, "R6 xfer ignored when disabled");

    // R4 / R5: forced request
    wr(8'h60, 8'hC0);
    rd_chk(8'h60, 8'hC0, "R4 force bit reads 1");
    rd_chk(8'h61, 8'h80, "R4 force sets flag");
    chk("R4 request from force", irq_req, 1'b1);
    wr(8'h60, 8'h80);
    rd_chk(8'h60, 8'hC0, "R4 force bit sticky");
    wr(8'h61, 8'h00);
    rd_chk(8'h61, 8'h80, "R5 zero write no effect");
    wr(8'h61, 8'h80);
    rd_chk(8'h61, 8'h00, "R5 flag cleared");
    rd_chk(8'h60, 8'h80, "R5 force bit cleared");

    // R7: set wins over clear
    wr(8'h60, 8'h81);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 8'h61; bus_wdata = 8'h80; xfer_done = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; xfer_done = 1'b0;
    rd_chk(8'h61, 8'h80, "R7 set wins");
    wr(8'h61, 8'h80);

    // R8 / R9: timer
    wr(8'h60, 8'h00);
    wr(8'h62, 8'h05);
    wr(8'h63, 8'h12);
    rd_chk(8'h63, 8'h12, "R8 reload high readback");
    wr(8'h63, 8'h00);
    rd_chk(8'h62, 8'h05, "R8 reload low readback");
    wr(8'h60, 8'hA0);
    count_ticks(25, k);
    chk("R8 period 5 standalone", k, 5);
    rd_chk(8'h61, 8'h80, "R9 timeout sets flag");
    chk("R9 timeout request", irq_req, 1'b1);
    wr(8'h60, 8'h81);
    wr(8'h61, 8'h80);
    count_ticks(20, k);
    chk("R8 period 5 while enabled", k, 4);
    rd_chk(8'h61, 8'h00, "R9 no timeout irq while enabled");
    wr(8'h60, 8'h00);
    count_ticks(20, k);
    chk("R8 halted", k, 0);
    wr(8'h62, 8'h01);
    wr(8'h60, 8'h20);
    count_ticks(10, k);
    chk("R8 reload 1", k, 10);
    wr(8'h62, 8'h00);
    count_ticks(10, k);
    chk("R8 reload 0", k, 10);
    wr(8'h60, 8'h00);
    wr(8'h61, 8'h80);

    // R10: SCK idle level and polarity
    wr(8'h60, 8'h08);
    @(posedge clk); #1;
    sh_sck_run = 1'b0; sh_oe = 4'hF; sh_out = 4'h0;
    @(negedge clk);
    chk("R10 idle high", pad_out[0], 1'b1);
    @(posedge clk); #1;
    sh_sck_run = 1'b1; sh_out = 4'h1;
    @(negedge clk);
    chk("R10 inverted running clock", pad_out[0], 1'b0);
    wr(8'h60, 8'h00);
    @(posedge clk); #1;
    sh_sck_run = 1'b0;
    @(negedge clk);
    chk("R10 idle low", pad_out[0], 1'b0);

    // R11: open-drain
    wr(8'h60, 8'h04);
    @(posedge clk); #1;
    sh_sck_run = 1'b1; sh_out = 4'b0101; sh_oe = 4'hF;
    @(negedge clk);
    chk("R11 od outputs low", pad_out, 4'h0);
    chk("R11 od enables", pad_oe, 4'b1010);

    // R12: configuration outputs
    wr(8'h60, 8'h1E);
    chk("R12 config bits", {cfg_en, cfg_master, cfg_od, cfg_cpol, cfg_cpha}, 5'b01111);
    wr(8'h60, 8'h00);

    // random phase against the model
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      bus_we     = ($urandom % 3) == 0;
      bus_addr   = 8'h60 + 8'($urandom % 5);
      bus_wdata  = 8'($urandom);
      if (bus_we && bus_addr == 8'h63) bus_wdata = 8'h00;
      xfer_done  = ($urandom % 4) == 0;
      sh_sck_run = 1'($urandom);
      sh_out     = 4'($urandom);
      sh_oe      = 4'($urandom);
    end
    @(posedge clk); #1;
    bus_we = 1'b0; xfer_done = 1'b0;
    repeat (3) @(posedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule